// File: doc/BRIEF.md
# Four-Channel Reloading Down-Count Timer

This peripheral holds a bank of independent 32-bit down counters that share one clock and sit behind a simple single-cycle register port. Software writes a reload value and turns a channel on. The channel then counts down to zero, sets a sticky event flag, refills itself from the reload register and keeps running. The time between events is therefore the reload value plus one clock. Each channel has its own interrupt line. That line is asserted while the channel's flag is set and its interrupt is allowed.

A channel other than the first can be linked to the channel below it. A linked channel steps once each time its lower neighbour wraps, so two channels together form one wider counter. A global stop bit freezes every channel at once. Changing a reload value never disturbs the period that is already running. To restart at once from the new value, software turns the channel off and then on again.

Reads are combinational: the read data follows the address in the same cycle. Writes take effect at the next rising clock edge.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and every interrupt output is low.
- R2: The address map uses byte addresses with 32-bit aligned words. The global control word is at 0x000, and bit 1 of it is the global stop. Channel n starts at 0x100 + 0x10*n and holds these words: reload at +0x0, live count at +0x4 (read only, writes ignored), control at +0x8 (bit 0 run, bit 1 interrupt allow, bit 2 link) and flag at +0xC (bit 0). Any other address reads zero, and writes to it change nothing.
- R3: A running, unlinked channel whose count is c steps to c-1 on each clock. From zero it reloads the reload value and sets its flag, so the events are reload+1 clocks apart.
- R4: Writing the reload register while the channel runs leaves the current count untouched. The new value is used at the next reload.
- R5: A control write that turns run from 0 to 1 loads the count from the reload register. A control write to a channel that is already running does not restart it.
- R6: A channel whose run bit is clear holds its count. While the global stop bit is set, every channel holds its count.
- R7: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R8: A channel's interrupt output equals its flag ANDed with its interrupt-allow bit.
- R9: A linked channel (n > 0) steps only in a cycle where channel n-1 wraps from zero. Channel 0 ignores its link bit and steps on every clock.
- R10: Once set, a flag stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the register access |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 4 | One interrupt line per channel |

## Verification
The bound checker watches every cycle for the following:
- the one-per-clock decrement and the reload-and-flag step of unlinked channels;
- counts that stay frozen while a channel is off, or while the global stop bit is set;
- linked channels that stay still whenever their neighbour is not at zero;
- flags that stay set when no write occurs.

Some behaviour can only be seen through register traffic, so the bench's scenarios show it instead:
- the reload value being deferred to the next reload;
- the restart on a 0-to-1 run write, and the absence of a restart when the channel is already running;
- clear-on-one and ignore-on-zero flag writes;
- interrupt gating;
- zero reads from unmapped addresses.

The bench sweeps reload values on every channel and compares the count and the flag against the arithmetic period.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;
  // control word bit positions
  localparam int CTL_RUN   = 0;
  localparam int CTL_IE    = 1;
  localparam int CTL_LINK  = 2;
  localparam int CTL_W     = 3;
  localparam int GLB_STOP  = 1;

  typedef struct packed {
    logic loadWr;
    logic ctrlWr;
    logic flagClr;
  } chStrobe_t;
endpackage

// File: rtl/tmr_bank_ctrl.sv
module tmr_bank_ctrl
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int CH_BASE = 'h100
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          wrEn,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chCount,
  input  logic [NUM_CH-1:0][DATA_W-1:0] chLoad,
  input  logic [NUM_CH-1:0][CTL_W-1:0]  chCtrl,
  input  logic [NUM_CH-1:0]             chFlag,
  output chStrobe_t [NUM_CH-1:0]        strobe,
  output logic                          modDis,
  output logic [DATA_W-1:0]             rdData
);
  localparam int CH_STRIDE = 16;

  logic              aligned;
  logic              glbHit;
  logic [1:0]        regSel;
  logic [NUM_CH-1:0] chHit;

  assign aligned = (addr[1:0] == 2'b00);
  assign glbHit  = (addr == '0);
  assign regSel  = addr[3:2];

  for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(CH_BASE + CH_STRIDE * n);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(CH_BASE + CH_STRIDE * (n + 1));
    assign chHit[n] = aligned && (addr >= LO) && (addr < HI);
  end

  always_ff @(posedge clk) begin
    if (rst) modDis <= 1'b0;
    else if (wrEn && glbHit) modDis <= wrData[GLB_STOP];
  end

  always_comb begin
    rdData = '0;
    strobe = '0;
    if (glbHit) rdData[GLB_STOP] = modDis;
    for (int n = 0; n < NUM_CH; n++) begin
      if (chHit[n]) begin
        case (regSel)
          2'd0: begin
            rdData = chLoad[n];
            strobe[n].loadWr = wrEn;
          end
          2'd1: rdData = chCount[n];
          2'd2: begin
            rdData = DATA_W'(chCtrl[n]);
            strobe[n].ctrlWr = wrEn;
          end
          default: begin
            rdData = DATA_W'(chFlag[n]);
            strobe[n].flagClr = wrEn && wrData[0];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_bank_dp.sv
module tmr_bank_dp
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  chStrobe_t [NUM_CH-1:0]        strobe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic                          modDis,
  output logic [NUM_CH-1:0][DATA_W-1:0] chCount,
  output logic [NUM_CH-1:0][DATA_W-1:0] chLoad,
  output logic [NUM_CH-1:0][CTL_W-1:0]  chCtrl,
  output logic [NUM_CH-1:0]             chFlag,
  output logic [NUM_CH-1:0]             irq
);
  logic [NUM_CH-1:0] expire;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [DATA_W-1:0] cnt, ld;
    logic [CTL_W-1:0]  ctl;
    logic              flg, tick, startNow;

    if (n == 0) begin : g_first
      assign tick = 1'b1;
    end else begin : g_link
      assign tick = ctl[CTL_LINK] ? expire[n-1] : 1'b1;
    end

    assign expire[n] = ctl[CTL_RUN] && !modDis && tick && (cnt == '0);
    assign startNow  = strobe[n].ctrlWr && wrData[CTL_RUN] && !ctl[CTL_RUN];

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
        ld  <= '0;
        ctl <= '0;
        flg <= 1'b0;
      end else begin
        if (strobe[n].loadWr) ld  <= wrData;
        if (strobe[n].ctrlWr) ctl <= wrData[CTL_W-1:0];
        if (startNow)                              cnt <= ld;
        else if (expire[n])                        cnt <= ld;
        else if (ctl[CTL_RUN] && !modDis && tick)  cnt <= cnt - 1'b1;
        if (expire[n])             flg <= 1'b1;
        else if (strobe[n].flagClr) flg <= 1'b0;
      end
    end

    assign chCount[n] = cnt;
    assign chLoad[n]  = ld;
    assign chCtrl[n]  = ctl;
    assign chFlag[n]  = flg;
    assign irq[n]     = flg && ctl[CTL_IE];
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter int CH_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq
);
  chStrobe_t [NUM_CH-1:0]        strobe;
  logic                          modDis;
  logic [NUM_CH-1:0][DATA_W-1:0] chCount, chLoad;
  logic [NUM_CH-1:0][CTL_W-1:0]  chCtrl;
  logic [NUM_CH-1:0]             chFlag;

  tmr_bank_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE)) ctrl_i (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .chCount(chCount), .chLoad(chLoad), .chCtrl(chCtrl), .chFlag(chFlag),
    .strobe(strobe), .modDis(modDis), .rdData(rdData)
  );

  tmr_bank_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .modDis(modDis),
    .chCount(chCount), .chLoad(chLoad), .chCtrl(chCtrl), .chFlag(chFlag), .irq(irq)
  );
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wrEn,
  input logic                          modDis,
  input logic [NUM_CH-1:0][DATA_W-1:0] chCount,
  input logic [NUM_CH-1:0][DATA_W-1:0] chLoad,
  input logic [NUM_CH-1:0][CTL_W-1:0]  chCtrl,
  input logic [NUM_CH-1:0]             chFlag
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    localparam bit FIRST = (n == 0);
    logic freeRun;
    assign freeRun = chCtrl[n][CTL_RUN] && !modDis && (FIRST || !chCtrl[n][CTL_LINK]);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (chFlag[n] && !wrEn) |=> chFlag[n]); // R10
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
      ((modDis || !chCtrl[n][CTL_RUN]) && !wrEn) |=> $stable(chCount[n])); // R6
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (freeRun && chCount[n] != '0 && !wrEn) |=> chCount[n] == $past(chCount[n]) - DATA_W'(1)); // R3
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (freeRun && chCount[n] == '0 && !wrEn) |=> (chCount[n] == $past(chLoad[n]) && chFlag[n])); // R3

    if (n > 0) begin : g_link
      AST_LINK_WAIT: assert property (@(posedge clk) disable iff (rst)
        (chCtrl[n][CTL_LINK] && chCount[n-1] != '0 && !wrEn) |=> $stable(chCount[n])); // R9
    end
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .wrEn(wrEn), .modDis(modDis),
  .chCount(chCount), .chLoad(chLoad), .chCtrl(chCtrl), .chFlag(chFlag)
);

// File: tb/tmr_bank_test.sv
module tmr_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irq;

  int total = 0;
  int bad = 0;
  logic [31:0] v, v2;

  tmr_bank uut (.clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .wrData(wrData),
                .rdData(rdData), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int chA(int n, int off);
    return 'h100 + 16 * n + off;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(int a, logic [31:0] d);
    addr = 12'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] r);
    addr = 12'(a);
    #1;
    r = rdData;
  endtask

  task automatic quiet();
    for (int n = 0; n < NCH; n++) begin
      wr(chA(n, 8), 0);
      wr(chA(n, 12), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(0, v); chk("R1 global", v, 0);
    for (int n = 0; n < NCH; n++)
      for (int o = 0; o < 16; o += 4) begin
        rd(chA(n, o), v); chk("R1 channel reg", v, 0);
      end
    chk("R1 irq", 32'(irq), 0);

    // R3 sweep: every channel, reload 1..5; channel 0 with link bit set (R9)
    for (int n = 0; n < NCH; n++)
      for (int L = 1; L <= 5; L++) begin
        quiet();
        wr(chA(n, 0), L);
        wr(chA(n, 8), (n == 0) ? 5 : 1);
        for (int k = 0; k <= 2 * L + 2; k++) begin
          rd(chA(n, 4), v);
          chk((n == 0) ? "R3 R9 ch0 count" : "R3 count", v, 32'(L - (k % (L + 1))));
          rd(chA(n, 12), v);
          chk("R3 R10 flag", v, (k >= L + 1) ? 1 : 0);
          @(negedge clk);
        end
      end

    // R9 linked pair: ch0 reload 2, ch1 linked reload 1
    quiet();
    wr(chA(0, 0), 2);
    wr(chA(1, 0), 1);
    wr(chA(1, 8), 5);
    wr(chA(0, 8), 1);
    for (int k = 0; k <= 12; k++) begin
      rd(chA(0, 4), v);  chk("R9 low count", v, 32'(2 - (k % 3)));
      rd(chA(1, 4), v);  chk("R9 linked count", v, 32'(1 - ((k / 3) % 2)));
      rd(chA(1, 12), v); chk("R9 linked flag", v, (k >= 6) ? 1 : 0);
      @(negedge clk);
    end

    // R4 reload written mid-period
    quiet();
    wr(chA(2, 0), 5);
    wr(chA(2, 8), 1);                       // k=0 count 5
    @(negedge clk); @(negedge clk);          // k=2 count 3
    wr(chA(2, 0), 1);                       // k=3
    rd(chA(2, 4), v); chk("R4 current period kept", v, 2);
    repeat (3) @(negedge clk);               // k=6
    rd(chA(2, 4), v); chk("R4 new reload used", v, 1);
    repeat (2) @(negedge clk);               // k=8
    rd(chA(2, 4), v); chk("R4 second period", v, 1);
    wr(chA(2, 8), 3);                       // k=9, already running
    rd(chA(2, 4), v); chk("R5 no restart when running", v, 0);
    wr(chA(2, 8), 0);
    wr(chA(2, 0), 4);
    wr(chA(2, 8), 1);
    rd(chA(2, 4), v); chk("R5 restart loads reload", v, 4);

    // R6 global stop and per-channel off
    quiet();
    wr(chA(3, 0), 100);
    wr(chA(3, 8), 1);
    wr(0, 2);
    rd(0, v); chk("R2 global stop readback", v, 2);
    rd(chA(3, 4), v);
    repeat (5) @(negedge clk);
    rd(chA(3, 4), v2); chk("R6 global stop holds", v2, v);
    wr(0, 0);
    rd(chA(3, 4), v2); chk("R6 still held on release edge", v2, v);
    @(negedge clk);
    rd(chA(3, 4), v2); chk("R6 resumes", v2, v - 1);
    wr(chA(3, 8), 0);
    rd(chA(3, 4), v);
    repeat (4) @(negedge clk);
    rd(chA(3, 4), v2); chk("R6 channel off holds", v2, v);
    wr(chA(3, 4), 32'h12345);
    rd(chA(3, 4), v2); chk("R2 count write ignored", v2, v);

    // R7 R8 flag and interrupt
    quiet();
    wr(chA(3, 0), 2);
    wr(chA(3, 8), 1);
    repeat (4) @(negedge clk);
    rd(chA(3, 12), v); chk("R3 flag set", v, 1);
    chk("R8 irq masked", 32'(irq), 0);
    wr(chA(3, 8), 3);
    chk("R8 irq allowed", 32'(irq), 8);
    wr(chA(3, 8), 2);
    wr(chA(3, 12), 0);
    rd(chA(3, 12), v); chk("R7 write zero keeps flag", v, 1);
    chk("R8 irq still up", 32'(irq), 8);
    wr(chA(3, 12), 1);
    rd(chA(3, 12), v); chk("R7 write one clears", v, 0);
    chk("R8 irq drops", 32'(irq), 0);
    rd(chA(3, 8), v); chk("R2 control readback", v, 2);

    // R2 unmapped
    wr('h004, 32'hFFFF_FFFF);
    wr('h140, 32'hFFFF_FFFF);
    rd('h004, v); chk("R2 unmapped 004", v, 0);
    rd('h140, v); chk("R2 unmapped 140", v, 0);
    rd('h0FC, v); chk("R2 unmapped 0FC", v, 0);
    rd('h102, v); chk("R2 misaligned", v, 0);
    rd(0, v); chk("R2 global unchanged", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule